// File: doc/BRIEF.md
# Power Mode Sequencer with Wake Control

This block tracks the power state of a small processor core. It has three resting states. In run, the CPU and the peripherals are clocked. In idle, the CPU clock is gated and the peripherals keep the selected clock. In sleep, every clock is stopped and the primary oscillator is switched off. A one-cycle sleep strobe, which stands for the sleep instruction, moves the core out of run. The idle-enable input and a two-bit clock-select field decide where it goes.

Three events can bring the core back to run: an interrupt flag whose own enable is set, a watchdog timeout strobe, or reset. Every exit passes a fixed prepare delay before the CPU clock returns. An oscillator start-up wait comes before that delay only when the primary crystal has to be restarted. After an interrupt wake with the global enable set, the block raises a one-cycle indication that the CPU must branch to the interrupt vector. The oscillators, the interrupt controller and instruction execution are outside the block and reach it only as input levels and strobes.

Clock-select encoding, used for `clk_sel_i` and `clk_src_o`: 2'b00 is the internal RC oscillator, 2'b01 is the primary oscillator, and 2'b10 and 2'b11 are the secondary oscillator. The secondary oscillator is modelled as always running.

Top module: `pms_sequencer`

## Requirements
- R1: After reset the block is in run. cpu_clk_en_o and periph_clk_en_o are 1, pri_osc_en_o, osc_ready_o and vec_branch_o are 0, and clk_src_o is 2'b00 (internal RC).
- R2: In run, a sleep_req_i strobe with idle_en_i=0 enters sleep. From the next cycle cpu_clk_en_o, periph_clk_en_o and pri_osc_en_o are 0, and osc_ready_o falls one cycle after the oscillator is disabled.
- R3: In run, a sleep_req_i strobe with idle_en_i=1 enters idle. cpu_clk_en_o is 0 and periph_clk_en_o is 1. clk_src_o takes the clk_sel_i value present with the strobe, and in run clk_src_o follows clk_sel_i one cycle later.
- R4: In idle with clk_src_o=2'b00, pri_osc_en_o is 0 and osc_ready_o is 0 from the second idle cycle on. This also holds when the preceding run used the primary oscillator.
- R5: Only a wake event ends sleep or idle. A wake event is a cycle with irq_flag_i[i] and irq_en_i[i] both 1 for some i, or with wdt_timeout_i=1. A flag whose enable is 0 has no effect.
- R6: On an exit without start-up wait, cpu_clk_en_o stays 0 for exactly PREP_CYCLES (default 10) cycles after the clock edge that samples the wake event, then returns to 1.
- R7: On a wake with clk_src_o=2'b01, osc_ready_o=0 and pri_ext_i=0, the primary oscillator is enabled. osc_ready_o rises after OST_CYCLES (default 1024) enabled cycles. cpu_clk_en_o returns to 1 OST_CYCLES+PREP_CYCLES+1 cycles after the wake edge.
- R8: The start-up wait is skipped when the primary oscillator is still ready (idle on the primary source) or when pri_ext_i=1. With pri_ext_i=1, osc_ready_o rises one cycle after pri_osc_en_o.
- R9: vec_branch_o is a one-cycle pulse in the first run cycle after an exit, and only when the wake was caused by an enabled interrupt flag with gie_i=1 at the wake edge. A watchdog wake or gie_i=0 gives no pulse.
- R10: Asserting rst_n low in any state returns the block to run with clk_src_o=2'b00.
- R11: In run, wake inputs have no effect. A sleep_req_i during the start-up wait or the prepare delay is ignored and does not lengthen the exit.
- R12: A wake does not alter the clock source. clk_src_o after the exit equals its value during sleep or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | One-cycle sleep instruction strobe |
| idle_en_i | input | 1 | 1: sleep request enters idle; 0: enters sleep |
| clk_sel_i | input | 2 | Requested clock source (00 RC, 01 primary, 1x secondary) |
| pri_ext_i | input | 1 | Primary source is an external clock needing no start-up |
| irq_flag_i | input | N_IRQ | Interrupt flags |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| wdt_timeout_i | input | 1 | Watchdog timeout strobe |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| pri_osc_en_o | output | 1 | Primary oscillator enable |
| osc_ready_o | output | 1 | Primary oscillator start-up complete |
| vec_branch_o | output | 1 | Branch-to-interrupt-vector pulse |
| clk_src_o | output | 2 | Clock source in use |

## Verification
A wrong internal state shows at the ports within one cycle, because every output comes straight from registered state: the state enum, the latched source and the oscillator-ready flag. A miscounted prepare or start-up counter shows only at the end of an exit, as a cpu_clk_en_o rise that comes early or late by a whole number of cycles. The bench therefore measures exit lengths exactly for each exit path. A lost wake cause or global-enable latch stays hidden until the first run cycle, where vec_branch_o appears or is missing. Each of these is compared every clock against a behavioural model and confirmed by directed cycle counts.

// File: rtl/pms_pkg.sv
package pms_pkg;

    localparam logic [1:0] SRC_RC  = 2'b00;
    localparam logic [1:0] SRC_PRI = 2'b01;

    typedef enum logic [2:0] {
        PM_RUN     = 3'd0,
        PM_IDLE    = 3'd1,
        PM_SLEEP   = 3'd2,
        PM_OSTWAIT = 3'd3,
        PM_PREP    = 3'd4
    } pm_state_e;

    typedef struct packed {
        pm_state_e  state;
        logic [1:0] src;
        logic       from_idle;
        logic       irq_cause;
        logic       gie_lat;
        logic       vec;
    } seq_regs_t;

    function automatic logic is_primary(input logic [1:0] sel);
        return sel == SRC_PRI;
    endfunction

endpackage

// File: rtl/pms_wake_detect.sv
module pms_wake_detect #(
    parameter int unsigned N_IRQ = 4
) (
    input  logic [N_IRQ-1:0] irq_flag_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    input  logic             wdt_timeout_i,
    output logic             irq_pend_o,
    output logic             wake_o
);

    logic [N_IRQ-1:0] qual;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_qual
        assign qual[g] = irq_flag_i[g] & irq_en_i[g];
    end

    assign irq_pend_o = |qual;
    assign wake_o     = irq_pend_o | wdt_timeout_i;

endmodule

// File: rtl/pms_osc_timer.sv
module pms_osc_timer #(
    parameter int unsigned OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic ext_i,
    output logic ready_o
);

    localparam int unsigned CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } ost_t;

    ost_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            s_d.cnt   = '0;
            s_d.ready = 1'b0;
        end else if (!s_q.ready) begin
            if (ext_i || s_q.cnt == LAST) begin
                s_d.ready = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o = s_q.ready;

    // R8: external clock source is ready one cycle after enable
    a_r8_ext_ready_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ext_i && !ready_o) |=> ready_o);

    // R2, R4: a disabled oscillator never reports ready
    a_r4_off_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !ready_o);

endmodule

// File: rtl/pms_prep_timer.sv
module pms_prep_timer #(
    parameter int unsigned PREP_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    localparam int unsigned CW = (PREP_CYCLES > 1) ? $clog2(PREP_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PREP_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign done_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || done_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R6: completion needs counting in the previous cycle
    a_r6_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(run_i));

endmodule

// File: rtl/pms_sequencer.sv
module pms_sequencer
    import pms_pkg::*;
#(
    parameter int unsigned N_IRQ       = 4,
    parameter int unsigned OST_CYCLES  = 1024,
    parameter int unsigned PREP_CYCLES = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req_i,
    input  logic             idle_en_i,
    input  logic [1:0]       clk_sel_i,
    input  logic             pri_ext_i,
    input  logic [N_IRQ-1:0] irq_flag_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    input  logic             gie_i,
    input  logic             wdt_timeout_i,
    output logic             cpu_clk_en_o,
    output logic             periph_clk_en_o,
    output logic             pri_osc_en_o,
    output logic             osc_ready_o,
    output logic             vec_branch_o,
    output logic [1:0]       clk_src_o
);

    seq_regs_t r_d, r_q;

    logic irq_pend;
    logic wake;
    logic osc_ready;
    logic prep_run;
    logic prep_done;
    logic need_ost;

    pms_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_flag_i    (irq_flag_i),
        .irq_en_i      (irq_en_i),
        .wdt_timeout_i (wdt_timeout_i),
        .irq_pend_o    (irq_pend),
        .wake_o        (wake)
    );

    pms_osc_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (pri_osc_en_o),
        .ext_i   (pri_ext_i),
        .ready_o (osc_ready)
    );

    assign prep_run = (r_q.state == PM_PREP);

    pms_prep_timer #(.PREP_CYCLES(PREP_CYCLES)) u_prep (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (prep_run),
        .done_o (prep_done)
    );

    // start-up wait only when the crystal must be restarted
    assign need_ost = is_primary(r_q.src) && !osc_ready && !pri_ext_i;

    always_comb begin
        r_d     = r_q;
        r_d.vec = 1'b0;
        unique case (r_q.state)
            PM_RUN: begin
                r_d.src = clk_sel_i;
                if (sleep_req_i) begin
                    r_d.state     = idle_en_i ? PM_IDLE : PM_SLEEP;
                    r_d.from_idle = idle_en_i;
                    r_d.irq_cause = 1'b0;
                end
            end
            PM_IDLE, PM_SLEEP: begin
                if (wake) begin
                    r_d.irq_cause = irq_pend;
                    r_d.gie_lat   = gie_i;
                    r_d.state     = need_ost ? PM_OSTWAIT : PM_PREP;
                end
            end
            PM_OSTWAIT: begin
                if (osc_ready) begin
                    r_d.state = PM_PREP;
                end
            end
            PM_PREP: begin
                if (prep_done) begin
                    r_d.state = PM_RUN;
                    r_d.vec   = r_q.irq_cause & r_q.gie_lat;
                end
            end
            default: r_d.state = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: PM_RUN, src: SRC_RC, from_idle: 1'b0,
                     irq_cause: 1'b0, gie_lat: 1'b0, vec: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_clk_en_o    = (r_q.state == PM_RUN);
    assign periph_clk_en_o = (r_q.state == PM_RUN) || (r_q.state == PM_IDLE) ||
                             (((r_q.state == PM_OSTWAIT) || (r_q.state == PM_PREP)) && r_q.from_idle);
    assign pri_osc_en_o    = (r_q.state != PM_SLEEP) && is_primary(r_q.src);
    assign osc_ready_o     = osc_ready;
    assign vec_branch_o    = r_q.vec;
    assign clk_src_o       = r_q.src;

    // R11: wake inputs do nothing while running
    a_r11_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PM_RUN && !sleep_req_i) |=> r_q.state == PM_RUN);

    // R11: an exit sequence never falls back to sleep or idle
    a_r11_exit_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PM_PREP || r_q.state == PM_OSTWAIT) |=>
        (r_q.state == PM_PREP || r_q.state == PM_OSTWAIT || r_q.state == PM_RUN));

    // R5: resting states hold without a wake event
    a_r5_rest_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == PM_SLEEP || r_q.state == PM_IDLE) && !wake) |=> $stable(r_q.state));

    // R6: the CPU clock only returns after the prepare delay completed
    a_r6_cpu_after_prep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en_o) |-> $past(prep_done));

    // R9: vector indication lasts a single cycle
    a_r9_vec_single: assert property (@(posedge clk) disable iff (!rst_n)
        vec_branch_o |=> !vec_branch_o);

    // R4: RC idle keeps the primary oscillator down
    a_r4_rc_idle_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PM_IDLE && r_q.src == SRC_RC) |=> !osc_ready_o);

    // R12: the source is held through an exit
    a_r12_src_held: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != PM_RUN) |=> $stable(clk_src_o));

endmodule

// File: tb/pms_sequencer_tb.sv
module pms_sequencer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NI   = 4;
    localparam int OST  = 1024;
    localparam int PREP = 10;
    localparam int WD_LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic          idle_en = 1'b0;
    logic [1:0]    clk_sel = 2'b00;
    logic          pri_ext = 1'b0;
    logic [NI-1:0] irq_flag = '0;
    logic [NI-1:0] irq_en = 4'b0001;
    logic          gie = 1'b0;
    logic          wdt = 1'b0;
    logic          cpu_en, per_en, pri_en, ready, vec;
    logic [1:0]    src;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pms_sequencer #(.N_IRQ(NI), .OST_CYCLES(OST), .PREP_CYCLES(PREP)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sleep_req_i     (sleep_req),
        .idle_en_i       (idle_en),
        .clk_sel_i       (clk_sel),
        .pri_ext_i       (pri_ext),
        .irq_flag_i      (irq_flag),
        .irq_en_i        (irq_en),
        .gie_i           (gie),
        .wdt_timeout_i   (wdt),
        .cpu_clk_en_o    (cpu_en),
        .periph_clk_en_o (per_en),
        .pri_osc_en_o    (pri_en),
        .osc_ready_o     (ready),
        .vec_branch_o    (vec),
        .clk_src_o       (src)
    );

    // behavioural reference: mode 0 run, 1 idle, 2 sleep, 3 start-up wait, 4 prepare
    int m_mode, m_src, m_ocnt, m_pcnt;
    bit m_fi, m_cause, m_gie, m_vec, m_ready;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_src = 0; m_ocnt = 0; m_pcnt = 0;
            m_fi = 0; m_cause = 0; m_gie = 0; m_vec = 0; m_ready = 0;
        end else begin
            automatic bit pend   = |(irq_flag & irq_en);
            automatic bit wk     = pend || wdt;
            automatic bit osc_on = (m_mode != 2) && (m_src == 1);
            automatic bit fin    = (m_mode == 4) && (m_pcnt == PREP - 1);
            automatic int n_mode = m_mode;
            automatic int n_src  = m_src;
            automatic bit n_fi = m_fi, n_cause = m_cause, n_gie = m_gie;
            automatic bit n_ready = m_ready;
            automatic int n_ocnt = m_ocnt;
            if (!osc_on) begin
                n_ready = 0; n_ocnt = 0;
            end else if (!m_ready) begin
                if (pri_ext || m_ocnt == OST - 1) n_ready = 1;
                else n_ocnt = m_ocnt + 1;
            end
            m_vec = 0;
            case (m_mode)
                0: begin
                    n_src = int'(clk_sel);
                    if (sleep_req) begin
                        n_mode = idle_en ? 1 : 2; n_fi = idle_en; n_cause = 0;
                    end
                end
                1, 2: if (wk) begin
                    n_cause = pend; n_gie = gie;
                    n_mode = (m_src == 1 && !m_ready && !pri_ext) ? 3 : 4;
                end
                3: if (m_ready) n_mode = 4;
                4: if (fin) begin n_mode = 0; m_vec = m_cause && m_gie; end
                default: n_mode = 0;
            endcase
            m_pcnt = (m_mode == 4 && !fin) ? m_pcnt + 1 : 0;
            m_mode = n_mode; m_src = n_src; m_fi = n_fi; m_cause = n_cause;
            m_gie = n_gie; m_ready = n_ready; m_ocnt = n_ocnt;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6",  "cpu_clk_en",    int'(cpu_en), int'(m_mode == 0));
            chk("R3",  "periph_clk_en", int'(per_en),
                int'(m_mode == 0 || m_mode == 1 || ((m_mode == 3 || m_mode == 4) && m_fi)));
            chk("R4",  "pri_osc_en",    int'(pri_en), int'(m_mode != 2 && m_src == 1));
            chk("R7",  "osc_ready",     int'(ready), int'(m_ready));
            chk("R9",  "vec_branch",    int'(vec), int'(m_vec));
            chk("R10", "clk_src",       int'(src), m_src);
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WD_LIMIT);
            summary();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter(input bit idle, input logic [1:0] sel);
        @(negedge clk);
        clk_sel = sel; idle_en = idle; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic wake_measure(input bit by_irq, input bit g, input bit poke_sleep,
                                output int len, output int vec_seen);
        @(negedge clk);
        if (by_irq) irq_flag = 4'b0001; else wdt = 1'b1;
        gie = g;
        @(negedge clk);
        irq_flag = '0; wdt = 1'b0;
        if (poke_sleep) sleep_req = 1'b1;
        len = 0;
        while (!cpu_en) begin
            len++;
            @(negedge clk);
            sleep_req = 1'b0;
        end
        vec_seen = int'(vec);
    endtask

    initial begin
        int len, vs;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1", "reset cpu_clk_en", int'(cpu_en), 1);
        chk("R1", "reset periph_clk_en", int'(per_en), 1);
        chk("R1", "reset pri_osc_en", int'(pri_en), 0);
        chk("R1", "reset osc_ready", int'(ready), 0);
        chk("R1", "reset clk_src", int'(src), 0);
        chk("R1", "reset vec_branch", int'(vec), 0);

        // sleep on RC, masked flag, then watchdog wake
        enter(1'b0, 2'b00);
        chk("R2", "sleep cpu_clk_en", int'(cpu_en), 0);
        chk("R2", "sleep periph_clk_en", int'(per_en), 0);
        irq_flag = 4'b0010;
        step(5);
        chk("R5", "masked flag keeps sleep", int'(cpu_en), 0);
        chk("R5", "masked flag keeps periph off", int'(per_en), 0);
        irq_flag = '0;
        wake_measure(1'b0, 1'b1, 1'b0, len, vs);
        chk("R6", "wdt exit length", len, PREP);
        chk("R9", "no vector after wdt wake", vs, 0);

        // RC idle, interrupt wake with gie, sleep request poked during prepare
        enter(1'b1, 2'b00);
        chk("R3", "idle cpu_clk_en", int'(cpu_en), 0);
        chk("R3", "idle periph_clk_en", int'(per_en), 1);
        chk("R4", "rc idle pri_osc_en", int'(pri_en), 0);
        wake_measure(1'b1, 1'b1, 1'b1, len, vs);
        chk("R11", "sleep request in prepare ignored, exit length", len, PREP);
        chk("R9", "vector pulse after irq wake with gie", vs, 1);
        step(1);
        chk("R9", "vector pulse ends", int'(vec), 0);
        step(3);
        chk("R11", "poked sleep request left core running", int'(cpu_en), 1);

        // wake inputs in run have no effect
        wdt = 1'b1; irq_flag = 4'b0001;
        step(3);
        wdt = 1'b0; irq_flag = '0;
        chk("R11", "wake inputs ignored in run", int'(cpu_en), 1);

        // primary source run, then primary idle
        clk_sel = 2'b01;
        step(OST + 20);
        chk("R3", "clk_src follows select in run", int'(src), 1);
        chk("R7", "primary ready after start-up", int'(ready), 1);
        enter(1'b1, 2'b01);
        step(1);
        chk("R8", "primary idle keeps ready", int'(ready), 1);
        chk("R8", "primary idle keeps oscillator", int'(pri_en), 1);
        wake_measure(1'b1, 1'b0, 1'b0, len, vs);
        chk("R8", "primary idle exit skips start-up", len, PREP);
        chk("R9", "no vector with gie low", vs, 0);
        chk("R12", "source kept after wake", int'(src), 1);

        // primary sleep: full start-up wait
        enter(1'b0, 2'b01);
        step(2);
        chk("R2", "sleep drops oscillator", int'(pri_en), 0);
        chk("R2", "sleep clears ready", int'(ready), 0);
        wake_measure(1'b1, 1'b1, 1'b0, len, vs);
        chk("R7", "start-up plus prepare length", len, OST + PREP + 1);
        chk("R9", "vector after long exit", vs, 1);

        // from primary run into RC idle
        step(2);
        enter(1'b1, 2'b00);
        step(1);
        chk("R4", "rc idle after primary run: osc off", int'(pri_en), 0);
        chk("R4", "rc idle after primary run: ready cleared", int'(ready), 0);
        chk("R4", "rc idle source", int'(src), 0);
        wake_measure(1'b0, 1'b0, 1'b0, len, vs);
        chk("R6", "rc idle exit length", len, PREP);

        // external primary clock
        pri_ext = 1'b1;
        clk_sel = 2'b01;
        step(4);
        chk("R8", "external source ready fast", int'(ready), 1);
        enter(1'b0, 2'b01);
        wake_measure(1'b0, 1'b0, 1'b0, len, vs);
        chk("R8", "external source sleep exit skips start-up", len, PREP);
        pri_ext = 1'b0;

        // reset while asleep on primary
        enter(1'b0, 2'b01);
        step(2);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        clk_sel = 2'b00;
        step(1);
        chk("R10", "reset exit forces RC source", int'(src), 0);
        chk("R10", "reset exit runs cpu", int'(cpu_en), 1);

        step(3);
        summary();
    end

endmodule